// File: doc/BRIEF.md
# Five-State Snoopy Coherence Tracker

This block keeps the coherence state of every line in a small write-back cache and decides, one transaction per cycle, how the cache takes part in a snooping bus protocol. Each line is in one of five states: invalid, clean and exclusive, modified and exclusive (owned), clean and shared, or modified and shared (owned). Clean shared copies may coexist with one modified owner, and that owner, not memory, must answer other caches' reads.

Two request streams arrive in the same cycle. The processor side presents a read, write or evict for one line index. The block answers with a hit flag, the line's current state, and the bus transaction the cache must issue, if any. The snoop side presents a transaction observed on the shared bus for one line index. The block answers with three flags: the local copy is being invalidated, the local owner supplies the data in place of memory, and a valid copy exists. All answers are combinational. State updates take effect at the next rising clock edge. Data storage, arbitration and memory are outside the block.

Top module: `coh_snoop_tracker`

## Requirements
- R1: After reset every line is Invalid. States are encoded Invalid=0, CleanExcl=1, OwnedExcl=2, CleanShared=3, OwnedShared=4 on `cpuState`. `cpuHit` is high only when `cpuValid` is set and the addressed line is not Invalid.
- R2: A processor read (`cpuOp`=0) of an Invalid line issues Coherent Read (`busCmd`=0). The line becomes CleanShared if `busSharedIn` is high in that cycle and CleanExcl otherwise. A read hit issues nothing and leaves the state unchanged.
- R3: A processor write (`cpuOp`=1) of an Invalid line issues Coherent Read and Invalidate (`busCmd`=1), and the line becomes OwnedExcl.
- R4: A write that hits CleanExcl moves the line to OwnedExcl with no bus transaction. A write that hits OwnedExcl issues nothing and keeps the state.
- R5: A write that hits CleanShared or OwnedShared issues Coherent Invalidate (`busCmd`=2), and the line becomes OwnedExcl.
- R6: An evict (`cpuOp`=2) of an owned line issues Block Write (`busCmd`=3). An evict of a clean or Invalid line issues nothing. Every evicted line becomes Invalid.
- R7: A snooped Coherent Read (`snpOp`=0) raises `snpSharedOut` when the line is valid and raises `snpIntervene` when the line is owned. It moves OwnedExcl to OwnedShared and CleanExcl to CleanShared, and leaves the shared states unchanged.
- R8: A snooped Coherent Read and Invalidate (1), Coherent Invalidate (2) or DMA Write and Invalidate (4) drives the line to Invalid, raising `snpInvalidate` when it was valid. On Coherent Read and Invalidate, an owned line also raises `snpIntervene`.
- R9: A snooped Block Write (`snpOp`=3) has no effect: no flag is raised and the line state is unchanged.
- R10: A line enters OwnedShared only from OwnedExcl. A CleanShared line that is snooped again stays CleanShared.
- R11: When a snoop and a processor request address the same line in one cycle, the snoop is applied first. `cpuState`, `cpuHit` and the bus command are all derived from the state after the snoop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| cpuValid | input | 1 | Processor request present |
| cpuOp | input | 2 | 0 read, 1 write, 2 evict |
| cpuIdx | input | IDX_W | Line index of processor request |
| busSharedIn | input | 1 | Shared response seen during own Coherent Read |
| cpuHit | output | 1 | Request hits a valid line |
| cpuState | output | 3 | State of the addressed line after any same-cycle snoop |
| busCmdValid | output | 1 | A bus transaction must be issued |
| busCmd | output | 3 | Transaction code, meaningful with busCmdValid |
| snpValid | input | 1 | Snooped transaction present |
| snpOp | input | 3 | Snooped transaction code, same coding as busCmd |
| snpIdx | input | IDX_W | Line index of snooped transaction |
| snpIntervene | output | 1 | Local owner supplies data instead of memory |
| snpInvalidate | output | 1 | Local valid copy is being invalidated |
| snpSharedOut | output | 1 | Local valid copy exists (shared response) |

## Verification
Directed sequences walk a single line through each transition: read misses with the shared response both low and high, a silent write upgrade, a shared write upgrade, and the clean-shared versus owned-shared results of a snooped read. The clean-shared versus owned-shared pair shows whether OwnedShared can be reached without passing through OwnedExcl. A snooped Block Write on an owned line, followed by a state read, shows whether that transaction is truly ignored. A same-cycle snoop and processor write on one line shows whether the snoop takes priority. Thousands of random cycles then mix both request streams over all lines, with index collisions made frequent, so that every state meets every operation.

// File: rtl/coh_pkg.sv
package coh_pkg;

  typedef enum logic [2:0] {
    ST_I  = 3'd0,
    ST_CE = 3'd1,
    ST_OE = 3'd2,
    ST_CS = 3'd3,
    ST_OS = 3'd4
  } coh_state_e;

  typedef enum logic [2:0] {
    BUS_CR  = 3'd0,
    BUS_CRI = 3'd1,
    BUS_CI  = 3'd2,
    BUS_WR  = 3'd3,
    BUS_CWI = 3'd4
  } bus_cmd_e;

  typedef enum logic [1:0] {
    CPU_RD = 2'd0,
    CPU_WR = 2'd1,
    CPU_EV = 2'd2
  } cpu_op_e;

  // strobes from control to the line array
  typedef struct packed {
    logic       snpWr;
    coh_state_e snpNext;
    logic       cpuWr;
    coh_state_e cpuNext;
  } coh_strobe_t;

  function automatic logic isOwned(coh_state_e s);
    return (s == ST_OE) || (s == ST_OS);
  endfunction

  function automatic logic isValidLine(coh_state_e s);
    return s != ST_I;
  endfunction

endpackage

// File: rtl/coh_line_array.sv
module coh_line_array
  import coh_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  coh_strobe_t                 strobe,
  input  logic [IDX_W-1:0]            cpuIdx,
  input  logic [IDX_W-1:0]            snpIdx,
  output coh_state_e                  cpuCur,
  output coh_state_e                  snpCur,
  output coh_state_e [NUM_LINES-1:0]  lineStates
);

  coh_state_e [NUM_LINES-1:0] linesQ;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(g);
    logic cpuHere;
    logic snpHere;
    assign cpuHere = strobe.cpuWr && (cpuIdx == MY_IDX);
    assign snpHere = strobe.snpWr && (snpIdx == MY_IDX);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        linesQ[g] <= ST_I;
      end else if (cpuHere) begin
        // processor result already accounts for a same-line snoop
        linesQ[g] <= strobe.cpuNext;
      end else if (snpHere) begin
        linesQ[g] <= strobe.snpNext;
      end
    end
  end

  always_comb begin
    cpuCur = ST_I;
    snpCur = ST_I;
    if (int'(cpuIdx) < NUM_LINES) cpuCur = linesQ[cpuIdx];
    if (int'(snpIdx) < NUM_LINES) snpCur = linesQ[snpIdx];
  end

  assign lineStates = linesQ;

endmodule

// File: rtl/coh_ctrl.sv
module coh_ctrl
  import coh_pkg::*;
(
  input  logic        cpuValid,
  input  logic [1:0]  cpuOp,
  input  logic        busSharedIn,
  input  logic        snpValid,
  input  logic [2:0]  snpOp,
  input  logic        sameIdx,
  input  coh_state_e  cpuCur,
  input  coh_state_e  snpCur,
  output coh_strobe_t strobe,
  output coh_state_e  cpuView,
  output logic        cpuHit,
  output logic        busCmdValid,
  output bus_cmd_e    busCmd,
  output logic        snpIntervene,
  output logic        snpInvalidate,
  output logic        snpSharedOut
);

  coh_state_e snpNext;
  coh_state_e cpuNext;
  logic       cpuOpLegal;

  // snoop side decision
  always_comb begin
    snpNext       = snpCur;
    snpIntervene  = 1'b0;
    snpInvalidate = 1'b0;
    snpSharedOut  = 1'b0;
    if (snpValid) begin
      case (snpOp)
        BUS_CR: begin
          snpSharedOut = isValidLine(snpCur);
          snpIntervene = isOwned(snpCur);
          if (snpCur == ST_OE) snpNext = ST_OS;
          else if (snpCur == ST_CE) snpNext = ST_CS;
        end
        BUS_CRI: begin
          snpIntervene  = isOwned(snpCur);
          snpInvalidate = isValidLine(snpCur);
          snpNext       = ST_I;
        end
        BUS_CI, BUS_CWI: begin
          snpInvalidate = isValidLine(snpCur);
          snpNext       = ST_I;
        end
        default: ;
      endcase
    end
  end

  // processor sees the line as the snoop leaves it
  assign cpuView = (snpValid && sameIdx) ? snpNext : cpuCur;
  assign cpuHit  = cpuValid && isValidLine(cpuView);

  always_comb begin
    cpuNext     = cpuView;
    busCmdValid = 1'b0;
    busCmd      = BUS_CR;
    cpuOpLegal  = 1'b0;
    if (cpuValid) begin
      case (cpuOp)
        CPU_RD: begin
          cpuOpLegal = 1'b1;
          if (cpuView == ST_I) begin
            busCmdValid = 1'b1;
            busCmd      = BUS_CR;
            cpuNext     = busSharedIn ? ST_CS : ST_CE;
          end
        end
        CPU_WR: begin
          cpuOpLegal = 1'b1;
          cpuNext    = ST_OE;
          case (cpuView)
            ST_I: begin
              busCmdValid = 1'b1;
              busCmd      = BUS_CRI;
            end
            ST_CS, ST_OS: begin
              busCmdValid = 1'b1;
              busCmd      = BUS_CI;
            end
            default: ;
          endcase
        end
        CPU_EV: begin
          cpuOpLegal = 1'b1;
          cpuNext    = ST_I;
          if (isOwned(cpuView)) begin
            busCmdValid = 1'b1;
            busCmd      = BUS_WR;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.snpWr   = snpValid && (snpNext != snpCur);
    strobe.snpNext = snpNext;
    strobe.cpuWr   = cpuOpLegal;
    strobe.cpuNext = cpuNext;
  end

endmodule

// File: rtl/coh_snoop_tracker.sv
module coh_snoop_tracker
  import coh_pkg::*;
#(
  parameter  int NUM_LINES = 8,
  localparam int IDX_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cpuValid,
  input  logic [1:0]       cpuOp,
  input  logic [IDX_W-1:0] cpuIdx,
  input  logic             busSharedIn,
  output logic             cpuHit,
  output logic [2:0]       cpuState,
  output logic             busCmdValid,
  output logic [2:0]       busCmd,
  input  logic             snpValid,
  input  logic [2:0]       snpOp,
  input  logic [IDX_W-1:0] snpIdx,
  output logic             snpIntervene,
  output logic             snpInvalidate,
  output logic             snpSharedOut
);

  coh_strobe_t                strobe;
  coh_state_e                 cpuCur;
  coh_state_e                 snpCur;
  coh_state_e                 cpuView;
  bus_cmd_e                   busCmdE;
  coh_state_e [NUM_LINES-1:0] lineStates;

  coh_line_array #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W)
  ) u_lines (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cpuIdx     (cpuIdx),
    .snpIdx     (snpIdx),
    .cpuCur     (cpuCur),
    .snpCur     (snpCur),
    .lineStates (lineStates)
  );

  coh_ctrl u_ctrl (
    .cpuValid      (cpuValid),
    .cpuOp         (cpuOp),
    .busSharedIn   (busSharedIn),
    .snpValid      (snpValid),
    .snpOp         (snpOp),
    .sameIdx       (cpuIdx == snpIdx),
    .cpuCur        (cpuCur),
    .snpCur        (snpCur),
    .strobe        (strobe),
    .cpuView       (cpuView),
    .cpuHit        (cpuHit),
    .busCmdValid   (busCmdValid),
    .busCmd        (busCmdE),
    .snpIntervene  (snpIntervene),
    .snpInvalidate (snpInvalidate),
    .snpSharedOut  (snpSharedOut)
  );

  assign cpuState = cpuView;
  assign busCmd   = busCmdE;

endmodule

// File: rtl/coh_snoop_tracker_chk.sv
module coh_snoop_tracker_chk #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        cpuValid,
  input logic [1:0]                  cpuOp,
  input logic [IDX_W-1:0]            cpuIdx,
  input logic                        cpuHit,
  input logic [2:0]                  cpuState,
  input logic                        busCmdValid,
  input logic [2:0]                  busCmd,
  input logic                        snpValid,
  input logic [2:0]                  snpOp,
  input logic [IDX_W-1:0]            snpIdx,
  input logic                        snpIntervene,
  input logic [NUM_LINES-1:0][2:0]   lineStates
);

  // R2
  rd_miss_issues_cr_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuOp == 2'd0 && !cpuHit) |-> (busCmdValid && busCmd == 3'd0));

  // R5
  shared_write_issues_ci_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuOp == 2'd1 && (cpuState == 3'd3 || cpuState == 3'd4))
      |-> (busCmdValid && busCmd == 3'd2));

  // R6
  evict_clears_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cpuValid && cpuOp == 2'd2) |=> (lineStates[$past(cpuIdx)] == 3'd0));

  // R7
  intervene_needs_owner_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpIntervene)
      |-> (lineStates[snpIdx] == 3'd2 || lineStates[snpIdx] == 3'd4));

  // R8
  dma_write_clears_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    (snpValid && snpOp == 3'd4 && !(cpuValid && cpuIdx == snpIdx))
      |=> (lineStates[$past(snpIdx)] == 3'd0));

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_os
    // R10
    os_entry_from_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
      (lineStates[g] == 3'd4 && $past(lineStates[g]) != 3'd4)
        |-> ($past(lineStates[g]) == 3'd2));
  end

endmodule

bind coh_snoop_tracker coh_snoop_tracker_chk #(
  .NUM_LINES (NUM_LINES),
  .IDX_W     (IDX_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cpuValid     (cpuValid),
  .cpuOp        (cpuOp),
  .cpuIdx       (cpuIdx),
  .cpuHit       (cpuHit),
  .cpuState     (cpuState),
  .busCmdValid  (busCmdValid),
  .busCmd       (busCmd),
  .snpValid     (snpValid),
  .snpOp        (snpOp),
  .snpIdx       (snpIdx),
  .snpIntervene (snpIntervene),
  .lineStates   (lineStates)
);

// File: tb/test_coh_snoop_tracker.sv
module test_coh_snoop_tracker;

  localparam int LINES = 8;
  localparam int IW    = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          cpuValid = 1'b0;
  logic [1:0]    cpuOp = '0;
  logic [IW-1:0] cpuIdx = '0;
  logic          busSharedIn = 1'b0;
  logic          cpuHit;
  logic [2:0]    cpuState;
  logic          busCmdValid;
  logic [2:0]    busCmd;
  logic          snpValid = 1'b0;
  logic [2:0]    snpOp = '0;
  logic [IW-1:0] snpIdx = '0;
  logic          snpIntervene;
  logic          snpInvalidate;
  logic          snpSharedOut;

  int  testCount = 0;
  int  failCount = 0;
  bit  finished  = 1'b0;
  int  mdl [LINES];

  always #4 clk = ~clk;

  coh_snoop_tracker #(.NUM_LINES(LINES)) i_coh_snoop_tracker (
    .clk(clk), .rstN(rstN), .cpuValid(cpuValid), .cpuOp(cpuOp), .cpuIdx(cpuIdx),
    .busSharedIn(busSharedIn), .cpuHit(cpuHit), .cpuState(cpuState),
    .busCmdValid(busCmdValid), .busCmd(busCmd), .snpValid(snpValid), .snpOp(snpOp),
    .snpIdx(snpIdx), .snpIntervene(snpIntervene), .snpInvalidate(snpInvalidate),
    .snpSharedOut(snpSharedOut)
  );

  task automatic chk(string req, string what, int act, int exp);
    testCount++;
    if (act != exp) begin
      failCount++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // expected snoop reaction: states 0 I,1 CE,2 OE,3 CS,4 OS
  function automatic void snoopModel(input int s, input int op, output int nxt,
                                     output bit sh, output bit iv, output bit inv);
    bit owned = (s == 2) || (s == 4);
    bit valid = (s != 0);
    nxt = s; sh = 0; iv = 0; inv = 0;
    case (op)
      0: begin sh = valid; iv = owned; if (s == 2) nxt = 4; else if (s == 1) nxt = 3; end
      1: begin iv = owned; inv = valid; nxt = 0; end
      2, 4: begin inv = valid; nxt = 0; end
      default: ;
    endcase
  endfunction

  function automatic void cpuModel(input int s, input int op, input bit shIn,
                                   output int nxt, output bit bv, output int cmd);
    nxt = s; bv = 0; cmd = 0;
    case (op)
      0: if (s == 0) begin bv = 1; cmd = 0; nxt = shIn ? 3 : 1; end
      1: begin
        nxt = 2;
        if (s == 0) begin bv = 1; cmd = 1; end
        else if (s == 3 || s == 4) begin bv = 1; cmd = 2; end
      end
      2: begin nxt = 0; if (s == 2 || s == 4) begin bv = 1; cmd = 3; end end
      default: ;
    endcase
  endfunction

  function automatic string cpuTag(int s, int op, bit collide);
    if (collide) return "R11";
    case (op)
      0: return "R2";
      1: return (s == 0) ? "R3" : ((s == 3 || s == 4) ? "R5" : "R4");
      2: return "R6";
      default: return "R1";
    endcase
  endfunction

  function automatic string snpTag(int op);
    case (op)
      0: return "R7";
      1, 2, 4: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic step(bit cv, int cop, int cidx, bit sh, bit sv, int sop, int sidx);
    int view, sNxt, cNxt, cmd;
    bit eSh, eIv, eInv, bv, collide;
    string ct, st;
    @(negedge clk);
    cpuValid = cv; cpuOp = 2'(cop); cpuIdx = IW'(cidx); busSharedIn = sh;
    snpValid = sv; snpOp = 3'(sop); snpIdx = IW'(sidx);
    #3;
    sNxt = mdl[sidx]; eSh = 0; eIv = 0; eInv = 0;
    if (sv) snoopModel(mdl[sidx], sop, sNxt, eSh, eIv, eInv);
    collide = sv && cv && (sidx == cidx);
    view = (sv && sidx == cidx) ? sNxt : mdl[cidx];
    cNxt = view; bv = 0; cmd = 0;
    if (cv) cpuModel(view, cop, sh, cNxt, bv, cmd);
    ct = cpuTag(view, cop, collide);
    st = snpTag(sv ? sop : 3);
    chk(ct, "cpuState", int'(cpuState), view);
    chk(ct, "cpuHit", int'(cpuHit), int'(cv && view != 0));
    chk(ct, "busCmdValid", int'(busCmdValid), int'(bv));
    if (bv) chk(ct, "busCmd", int'(busCmd), cmd);
    chk(st, "snpSharedOut", int'(snpSharedOut), int'(eSh));
    chk(st, "snpIntervene", int'(snpIntervene), int'(eIv));
    chk(st, "snpInvalidate", int'(snpInvalidate), int'(eInv));
    if (sv) mdl[sidx] = sNxt;
    if (cv && cop < 3) mdl[cidx] = cNxt;
  endtask

  task automatic peek(string req, int idx, int exp);
    @(negedge clk);
    cpuValid = 0; snpValid = 0; cpuIdx = IW'(idx);
    #3;
    chk(req, "lineState", int'(cpuState), exp);
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      failCount++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd7315));
    for (int i = 0; i < LINES; i++) mdl[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1'b1;
    // R1 reset state
    for (int i = 0; i < LINES; i++) peek("R1", i, 0);

    // R2 read miss, shared low then high
    step(1, 0, 1, 0, 0, 0, 0);
    peek("R2", 1, 1);
    step(1, 0, 2, 1, 0, 0, 0);
    peek("R2", 2, 3);
    step(1, 0, 1, 1, 0, 0, 0);          // read hit, nothing issued
    // R4 silent upgrade
    step(1, 1, 1, 0, 0, 0, 0);
    peek("R4", 1, 2);
    // R9 snooped block write ignored on owner
    step(0, 0, 1, 0, 1, 3, 1);
    peek("R9", 1, 2);
    // R7 snoop read on owner -> OS with intervention
    step(0, 0, 1, 0, 1, 0, 1);
    peek("R7", 1, 4);
    // R10 CE -> CS, snooped again stays CS, write -> OE, snoop -> OS
    step(1, 0, 5, 0, 0, 0, 0);
    step(0, 0, 5, 0, 1, 0, 5);
    step(0, 0, 5, 0, 1, 0, 5);
    peek("R10", 5, 3);
    step(1, 1, 5, 0, 0, 0, 0);          // R5 CI
    peek("R5", 5, 2);
    step(0, 0, 5, 0, 1, 0, 5);
    peek("R10", 5, 4);
    // R6 evict owned shared
    step(1, 2, 5, 0, 0, 0, 0);
    peek("R6", 5, 0);
    // R3 write miss
    step(1, 1, 6, 0, 0, 0, 0);
    peek("R3", 6, 2);
    // R8 DMA write invalidate, and CRI intervention
    step(0, 0, 6, 0, 1, 4, 6);
    peek("R8", 6, 0);
    step(1, 1, 7, 0, 0, 0, 0);
    step(0, 0, 7, 0, 1, 1, 7);
    peek("R8", 7, 0);
    // R11 snoop invalidate and write to same CE line in one cycle
    step(1, 0, 3, 0, 0, 0, 0);
    step(1, 1, 3, 0, 1, 2, 3);
    peek("R11", 3, 2);

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int ci = $urandom_range(0, LINES - 1);
      int si = ($urandom_range(0, 3) == 0) ? ci : $urandom_range(0, LINES - 1);
      step($urandom_range(0, 3) != 0, $urandom_range(0, 2), ci, $urandom_range(0, 1) != 0,
           $urandom_range(0, 1) != 0, $urandom_range(0, 4), si);
    end
    for (int i = 0; i < LINES; i++) peek("R1", i, mdl[i]);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule